// File: doc/BRIEF.md
# Thread Execution Watchdog Timer

This block guards a microcoded service engine against threads that hold the engine too long. Every microcycle in which the engine is occupied with a thread adds one to an internal count: while it schedules the thread, while it executes an instruction, or while it stalls on a memory wait-state. The count is compared against a programmable limit. Once the count is strictly above the limit, the block asks the engine to end the running thread at its next instruction cycle. The same event produces a one-cycle global exception pulse and sets a sticky timeout flag.

A mode bit chooses when the count restarts. In per-thread mode it restarts at each thread end. In per-busy-period mode it restarts only when the engine goes idle, so a chain of back-to-back threads shares one budget. A forced end always restarts the count, so a thread that begins on the following microcycle gets a fresh budget. The count saturates rather than wrapping. It holds while the engine is stopped and is cleared while the watchdog is disabled. A small write port sets the limit, the mode and the enable, and clears the timeout flag.

Top module: `thread_wdog`

## Requirements
- R1: While the enable bit (control word bit 0) is 0, the count is held at zero and no forced end occurs. Disabling the watchdog discards any accumulated count.
- R2: With limit L, a thread that executes instructions continuously from a zero count is forced to end on its (L+2)-th counted microcycle, which is the first cycle whose count is L+1.
- R3: A thread whose final instruction cycle sees a count equal to L ends normally, without a forced end.
- R4: A forced end is accompanied in the same cycle by a one-cycle exception pulse. The timeout flag is 0 after reset, is 1 from the next cycle on, and stays set until a control write with bit 2 set clears it.
- R5: In per-thread mode (control bit 1 = 0), the count returns to zero after every thread end, so back-to-back threads each get the full limit.
- R6: In per-busy-period mode (control bit 1 = 1), the count keeps accumulating across thread ends with no idle cycle between them, and it returns to zero on an idle cycle.
- R7: After a forced end the count restarts from zero in both modes, so a thread starting on the very next cycle gets the full limit.
- R8: Scheduling-phase cycles and memory wait-state cycles add to the count just as instruction cycles do.
- R9: No forced end is raised during a scheduling-phase cycle. If the limit is passed while scheduling, the forced end is raised on the thread's first instruction cycle.
- R10: While the stopped input is high, the count neither advances nor clears, and no forced end is raised.
- R11: The count saturates at its maximum. A scheduling phase longer than twice the largest limit still leads to a forced end on the first instruction.
- R12: A write to address 1 loads the limit. A write to address 0 loads enable (bit 0) and mode (bit 1). Both take effect from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Microcycle clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 = control word, 1 = limit |
| cfg_wdata | input | LIMIT_W | Write data |
| eng_active | input | 1 | Engine executes an instruction of a thread this cycle |
| eng_sched | input | 1 | Engine is in the thread-scheduling phase |
| eng_wait | input | 1 | Engine stalls on a memory wait-state within a thread |
| eng_thread_end | input | 1 | This instruction cycle is the thread's last |
| eng_idle | input | 1 | Engine has no thread this cycle |
| eng_stopped | input | 1 | Engine clock is stopped for this cycle |
| force_end | output | 1 | Request to end the running thread now |
| exc_pulse | output | 1 | One-cycle global exception |
| timeout_flag | output | 1 | Sticky timeout status |

## Verification
The checker assumes the engine status inputs are consistent with each other. Idle never coincides with scheduling, execution or a wait-state. Scheduling and instruction execution are mutually exclusive. A thread end is only signalled together with an instruction cycle. The bench builds every cycle through one step task whose callers respect these rules. Configuration writes happen only while the engine sits idle or stopped, so a write never races a thread boundary.

// File: rtl/thread_wdog_pkg.sv
// Package: shared encodings for the thread watchdog.
// Assumes: control word bit positions are fixed as listed here.
package thread_wdog_pkg;
    typedef enum logic {
        MODE_PER_THREAD = 1'b0,
        MODE_PER_BUSY   = 1'b1
    } wd_mode_e;

    localparam logic ADDR_CTRL  = 1'b0;
    localparam logic ADDR_LIMIT = 1'b1;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_MODE_BIT = 1;
    localparam int CTRL_CLR_BIT  = 2;
endpackage

// File: rtl/thread_wdog_cfg.sv
// Module: configuration and status registers of the watchdog.
// Holds enable, mode, limit and the sticky timeout flag.
// Assumes LIMIT_W >= 3 so the control bits fit in the write data.
module thread_wdog_cfg
    import thread_wdog_pkg::*;
#(
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               addr,
    input  logic [LIMIT_W-1:0] wdata,
    input  logic               trip,
    output logic               en_q,
    output wd_mode_e           mode_q,
    output logic [LIMIT_W-1:0] limit_q,
    output logic               flag_q
);
    logic ctrl_wr;
    logic limit_wr;

    // Decode which register a write targets.
    always_comb begin
        ctrl_wr  = wr_en && (addr == ADDR_CTRL);
        limit_wr = wr_en && (addr == ADDR_LIMIT);
    end

    // Control word: enable and mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= MODE_PER_THREAD;
        end else if (ctrl_wr) begin
            en_q   <= wdata[CTRL_EN_BIT];
            mode_q <= wd_mode_e'(wdata[CTRL_MODE_BIT]);
        end
    end

    // Limit register; resets to the largest value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= '1;
        end else if (limit_wr) begin
            limit_q <= wdata;
        end
    end

    // Sticky timeout flag; a new timeout wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (trip) begin
            flag_q <= 1'b1;
        end else if (ctrl_wr && wdata[CTRL_CLR_BIT]) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/thread_wdog_counter.sv
// Module: saturating microcycle counter of the watchdog.
// Restarts on disable, forced end, idle, and (per-thread mode) thread end.
// Assumes the engine status inputs are mutually consistent.
module thread_wdog_counter
    import thread_wdog_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  wd_mode_e         mode,
    input  logic             busy,
    input  logic             thread_end,
    input  logic             idle,
    input  logic             stopped,
    input  logic             trip,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic restart;
    logic [CNT_W-1:0] cnt_inc;

    // Work out the restart condition and the saturated increment.
    always_comb begin
        restart = trip || idle ||
                  (thread_end && (mode == MODE_PER_THREAD));
        cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
    end

    // Count update: disable clears, stop holds, otherwise restart or count.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (stopped) begin
            cnt_q <= cnt_q;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (busy) begin
            cnt_q <= cnt_inc;
        end
    end
endmodule

// File: rtl/thread_wdog_trip.sv
// Module: timeout decision of the watchdog.
// Fires on an instruction cycle whose count is above the limit.
// A limit passed while scheduling stays pending until the first instruction.
module thread_wdog_trip #(
    parameter int LIMIT_W = 16,
    parameter int CNT_W   = 17
) (
    input  logic               en,
    input  logic               stopped,
    input  logic               active,
    input  logic               sched,
    input  logic [CNT_W-1:0]   cnt,
    input  logic [LIMIT_W-1:0] limit,
    output logic               trip
);
    logic over;

    // Strict comparison: a count equal to the limit is still allowed.
    always_comb begin
        over = cnt > CNT_W'(limit);
        trip = en && !stopped && active && !sched && over;
    end
endmodule

// File: rtl/thread_wdog.sv
// Module: thread execution watchdog, top level.
// Counts occupied microcycles and forces a thread end past the limit.
// Assumes one clock per microcycle and consistent engine status inputs.
module thread_wdog
    import thread_wdog_pkg::*;
#(
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic               cfg_addr,
    input  logic [LIMIT_W-1:0] cfg_wdata,
    input  logic               eng_active,
    input  logic               eng_sched,
    input  logic               eng_wait,
    input  logic               eng_thread_end,
    input  logic               eng_idle,
    input  logic               eng_stopped,
    output logic               force_end,
    output logic               exc_pulse,
    output logic               timeout_flag
);
    localparam int CNT_W = LIMIT_W + 1;

    logic               en_q;
    wd_mode_e           mode_q;
    logic [LIMIT_W-1:0] limit_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               trip;
    logic               busy;

    // A cycle is occupied by a thread when scheduling, executing or stalled.
    always_comb begin
        busy = eng_active || eng_sched || eng_wait;
    end

    thread_wdog_cfg #(.LIMIT_W(LIMIT_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .trip    (trip),
        .en_q    (en_q),
        .mode_q  (mode_q),
        .limit_q (limit_q),
        .flag_q  (timeout_flag)
    );

    thread_wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_q),
        .mode       (mode_q),
        .busy       (busy),
        .thread_end (eng_thread_end),
        .idle       (eng_idle),
        .stopped    (eng_stopped),
        .trip       (trip),
        .cnt_q      (cnt_q)
    );

    thread_wdog_trip #(.LIMIT_W(LIMIT_W), .CNT_W(CNT_W)) u_trip (
        .en      (en_q),
        .stopped (eng_stopped),
        .active  (eng_active),
        .sched   (eng_sched),
        .cnt     (cnt_q),
        .limit   (limit_q),
        .trip    (trip)
    );

    // The forced end and the exception share one timeout event.
    always_comb begin
        force_end = trip;
        exc_pulse = trip;
    end
endmodule

// File: rtl/thread_wdog_chk.sv
// Module: assertion checker for thread_wdog, attached by bind.
// Assumes consistent engine status inputs, as stated in the brief.
module thread_wdog_chk
    import thread_wdog_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_q,
    input wd_mode_e         mode_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             eng_active,
    input logic             eng_sched,
    input logic             eng_thread_end,
    input logic             eng_idle,
    input logic             eng_stopped,
    input logic             force_end,
    input logic             exc_pulse,
    input logic             timeout_flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    a_r1_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (cnt_q == '0));

    a_r4_flag_after_force: assert property (@(posedge clk) disable iff (!rst_n)
        force_end |=> timeout_flag);

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pulse |=> !exc_pulse);

    a_r5_thread_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && mode_q == MODE_PER_THREAD && eng_thread_end && !eng_stopped)
        |=> (cnt_q == '0));

    a_r6_busy_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && mode_q == MODE_PER_BUSY && eng_thread_end && eng_active &&
         !eng_stopped && !eng_idle && !force_end) |=> (cnt_q != '0));

    a_r7_force_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        force_end |=> (cnt_q == '0));

    a_r9_no_force_in_sched: assert property (@(posedge clk) disable iff (!rst_n)
        eng_sched |-> !force_end);

    a_r10_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && eng_stopped) |=> $stable(cnt_q));

    a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX || cnt_q == '0));
endmodule

bind thread_wdog thread_wdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .en_q           (en_q),
    .mode_q         (mode_q),
    .cnt_q          (cnt_q),
    .eng_active     (eng_active),
    .eng_sched      (eng_sched),
    .eng_thread_end (eng_thread_end),
    .eng_idle       (eng_idle),
    .eng_stopped    (eng_stopped),
    .force_end      (force_end),
    .exc_pulse      (exc_pulse),
    .timeout_flag   (timeout_flag)
);

// File: tb/thread_wdog_bench.sv
// Directed bench for thread_wdog; one task per scenario.
module thread_wdog_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LW         = 8;
    localparam int WATCHDOG   = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic          cfg_addr = 1'b0;
    logic [LW-1:0] cfg_wdata = '0;
    logic          eng_active = 1'b0;
    logic          eng_sched = 1'b0;
    logic          eng_wait = 1'b0;
    logic          eng_thread_end = 1'b0;
    logic          eng_idle = 1'b1;
    logic          eng_stopped = 1'b0;
    logic          force_end;
    logic          exc_pulse;
    logic          timeout_flag;

    int n_checks = 0;
    int n_fail   = 0;
    logic s_force, s_exc, s_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    thread_wdog #(.LIMIT_W(LW)) u_thread_wdog (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_wr_en      (cfg_wr_en),
        .cfg_addr       (cfg_addr),
        .cfg_wdata      (cfg_wdata),
        .eng_active     (eng_active),
        .eng_sched      (eng_sched),
        .eng_wait       (eng_wait),
        .eng_thread_end (eng_thread_end),
        .eng_idle       (eng_idle),
        .eng_stopped    (eng_stopped),
        .force_end      (force_end),
        .exc_pulse      (exc_pulse),
        .timeout_flag   (timeout_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One microcycle: drive at the falling edge, sample outputs just after.
    task automatic step(input logic a, s, w, e, i, st);
        @(negedge clk);
        eng_active = a; eng_sched = s; eng_wait = w;
        eng_thread_end = e; eng_idle = i; eng_stopped = st;
        #1;
        s_force = force_end; s_exc = exc_pulse; s_flag = timeout_flag;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 1, 0);
    endtask

    task automatic wr(input logic a, input logic [LW-1:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        #1 cfg_wr_en = 1'b0;
    endtask

    // Control word: bit0 enable, bit1 busy mode, bit2 clear flag.
    task automatic setup(input logic busy_mode, input int lim);
        idle(1);
        wr(1'b1, LW'(lim));
        wr(1'b0, LW'({busy_mode, 1'b1}));
        idle(1);
    endtask

    // Runs a thread; fidx = instruction index of forced end, -1 if none.
    task automatic run_thr(input int ns, input int na, output int fidx, output int xerr);
        fidx = -1; xerr = 0;
        for (int k = 0; k < ns; k++) begin
            step(0, 1, 0, 0, 0, 0);
            if (s_force) xerr++;
        end
        for (int j = 0; j < na; j++) begin
            step(1, 0, 0, (j == na - 1), 0, 0);
            if (s_exc != s_force) xerr++;
            if (s_force) begin
                fidx = j;
                break;
            end
        end
    endtask

    task automatic t_reset();
        step(0, 0, 0, 0, 1, 0);
        chk(!s_force, "R4 reset force", s_force, 0);
        chk(!s_exc,   "R4 reset exc",   s_exc,   0);
        chk(!s_flag,  "R4 reset flag",  s_flag,  0);
    endtask

    task automatic t_limit_edge();
        int f, x;
        setup(0, 5);
        run_thr(0, 6, f, x);
        chk(f == -1, "R3 equal count allowed", f, -1);
        idle(1);
        run_thr(0, 9, f, x);
        chk(f == 6, "R2 forced index", f, 6);
        chk(x == 0, "R4 exc with force", x, 0);
        idle(1);
        chk(s_flag, "R4 flag set", s_flag, 1);
        idle(3);
        chk(s_flag, "R4 flag sticky", s_flag, 1);
        wr(1'b0, LW'(3'b101));
        idle(1);
        chk(!s_flag, "R4 flag cleared", s_flag, 0);
    endtask

    task automatic t_limit_write();
        int f, x;
        setup(0, 2);
        run_thr(0, 9, f, x);
        chk(f == 3, "R12 new limit used", f, 3);
        idle(1);
    endtask

    task automatic t_thread_mode();
        int f, x, g;
        setup(0, 5);
        run_thr(0, 6, f, x);
        run_thr(0, 6, g, x);
        chk(f == -1 && g == -1, "R5 back-to-back threads", g, -1);
        idle(1);
    endtask

    task automatic t_busy_mode();
        int f, x;
        setup(1, 5);
        run_thr(0, 4, f, x);
        run_thr(0, 6, f, x);
        chk(f == 2, "R6 accumulates across threads", f, 2);
        idle(1);
        run_thr(0, 4, f, x);
        idle(1);
        run_thr(0, 6, f, x);
        chk(f == -1, "R6 idle restarts count", f, -1);
        idle(1);
    endtask

    task automatic t_rearm();
        int f, x;
        setup(1, 5);
        run_thr(0, 10, f, x);
        chk(f == 6, "R7 first thread forced", f, 6);
        run_thr(0, 6, f, x);
        chk(f == -1, "R7 next thread fresh", f, -1);
        idle(1);
        wr(1'b0, LW'(3'b111));
    endtask

    task automatic t_sched_wait();
        int f, x, fw;
        setup(0, 5);
        run_thr(3, 8, f, x);
        chk(f == 3, "R8 scheduling counted", f, 3);
        idle(1);
        fw = -1;
        step(1, 0, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) step(0, 0, 1, 0, 0, 0);
        for (int j = 0; j < 3; j++) begin
            step(1, 0, 0, (j == 2), 0, 0);
            if (s_force && fw < 0) fw = j;
            if (s_force) break;
        end
        chk(fw == 1, "R8 wait-states counted", fw, 1);
        idle(1);
    endtask

    task automatic t_deferred();
        int f, x;
        setup(0, 5);
        run_thr(8, 3, f, x);
        chk(x == 0, "R9 no force while scheduling", x, 0);
        chk(f == 0, "R9 force on first instruction", f, 0);
        idle(1);
    endtask

    task automatic t_stopped();
        int hits = 0;
        int f, x;
        setup(0, 5);
        for (int j = 0; j < 3; j++) step(1, 0, 0, 0, 0, 0);
        for (int k = 0; k < 10; k++) begin
            step(1, 0, 0, 0, 0, 1);
            if (s_force) hits++;
        end
        chk(hits == 0, "R10 no force while stopped", hits, 0);
        run_thr(0, 3, f, x);
        chk(f == -1, "R10 count held while stopped", f, -1);
        idle(1);
    endtask

    task automatic t_disable();
        int f, x;
        setup(1, 5);
        run_thr(0, 4, f, x);
        step(0, 0, 0, 0, 0, 1);
        wr(1'b0, LW'(3'b010));
        wr(1'b0, LW'(3'b011));
        run_thr(0, 6, f, x);
        chk(f == -1, "R1 disable discards count", f, -1);
        idle(1);
        wr(1'b0, LW'(3'b000));
        idle(1);
        run_thr(0, 12, f, x);
        chk(f == -1, "R1 disabled never forces", f, -1);
        idle(1);
    endtask

    task automatic t_saturate();
        int f, x;
        setup(0, 255);
        run_thr(600, 2, f, x);
        chk(x == 0, "R11 no force in long scheduling", x, 0);
        chk(f == 0, "R11 saturated count still forces", f, 0);
        idle(1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_limit_edge();
        t_limit_write();
        t_thread_mode();
        t_busy_mode();
        t_rearm();
        t_sched_wait();
        t_deferred();
        t_stopped();
        t_disable();
        t_saturate();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule